// File: doc/BRIEF.md
# Sample Min/Max/Mean Engine

This block keeps a bank of 32 unsigned samples, each `DW` bits wide, in its own storage. A host fills the bank one word per clock through a write strobe, a 5-bit index and a data bus. It then raises a start request. The engine walks the bank from index 0 up to index 31, one sample per clock. During the walk it tracks the smallest sample, the largest sample and the running total. When the walk is over it raises `done`.

While `done` is high, the host picks one result at a time with a 2-bit selector. The mean is the total divided by 32, with the fraction dropped. The start request works as a level handshake. The host keeps it high until it sees `done`, reads the results, and then lowers it. Lowering it clears `done` and sends the engine back to idle.

Top module: `minmaxavg`

## Requirements
- R1: While the engine is not scanning, a clock edge with `wr_en` high stores `wr_data` into the bank entry chosen by the 5-bit `wr_addr`. There are 32 entries, indexed 0 to 31.
- R2: A `start` sampled high in idle begins a scan. `done` is first seen high after the 33rd rising edge that follows the edge which sampled `start`.
- R3: At scan start the minimum is set to all ones and the maximum to zero. A sample replaces the minimum only if it is strictly smaller, and replaces the maximum only if it is strictly larger. After the scan these hold the true minimum and maximum of the 32 samples.
- R4: The total is `DW+5` bits wide, so it cannot overflow even when all samples are at full scale. The mean equals total >> 5, that is, truncation.
- R5: `res` returns a value chosen by `sel`: the minimum for code 2'b01, the maximum for 2'b10, the mean for 2'b11, and zero for 2'b00.
- R6: `done` stays high for as long as `start` stays high. One edge after `start` is sampled low, `done` is low and the engine is idle.
- R7: A write that arrives during a scan leaves the bank unchanged.
- R8: `rst`, which is synchronous and active high, clears every bank entry and every result register and lowers `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bank write strobe |
| wr_addr | input | 5 | Bank entry index |
| wr_data | input | DW | Sample to store |
| start | input | 1 | Scan request, held until done is seen |
| done | output | 1 | Results ready |
| sel | input | 2 | Result select: 01 min, 10 max, 11 mean, 00 zero |
| res | output | DW | Selected result |

## Verification
The scan result is due a fixed 34 sampled cycles after the bench raises `start`. The bench counts falling edges from that point and requires `done` to first appear exactly at that count. All three results are combinational reads of registers that are stable while `done` is high, so each selector code is applied and checked on the falling edge that follows it. The drop of `done` is checked at the first falling edge after `start` is lowered. The test for ignored writes reads back a rescan of the bank, not any internal state.

// File: rtl/minmaxavg.sv
module minmaxavg #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  output logic          done,
  input  logic [1:0]    sel,
  output logic [DW-1:0] res
);
  localparam int N  = 1 << AW;
  localparam int SW = DW + AW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  logic [DW-1:0] mem [N];
  st_t           state;
  logic [AW:0]   idx;
  logic [DW-1:0] mn, mx;
  logic [SW-1:0] sum;

  wire [DW-1:0] smp = mem[idx[AW-1:0]];
  wire [DW-1:0] avg = sum[SW-1:AW];

  assign done = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) mem[k] <= '0;
    end else if (wr_en && state != S_RUN) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      idx   <= '0;
      mn    <= '0;
      mx    <= '0;
      sum   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          idx   <= '0;
          mn    <= '1;
          mx    <= '0;
          sum   <= '0;
        end
        S_RUN: begin
          if (idx[AW]) begin
            state <= S_FIN;
          end else begin
            sum <= sum + SW'(smp);
            if (smp < mn) mn <= smp;
            if (smp > mx) mx <= smp;
            idx <= idx + 1'b1;
          end
        end
        S_FIN: if (!start) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'b01:   res = mn;
      2'b10:   res = mx;
      2'b11:   res = avg;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/minmaxavg_chk.sv
module minmaxavg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [DW-1:0] mn,
  input logic [DW-1:0] mx,
  input logic [DW-1:0] avg
);
  AST_RESET_DONE_LOW: assert property (@(posedge clk) rst |=> !done); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst) (done && start) |=> done); // R6
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> !done); // R6
  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst) done |-> (mn <= mx)); // R3
  AST_MEAN_BOUNDED: assert property (@(posedge clk) disable iff (rst) done |-> (avg >= mn && avg <= mx)); // R4
endmodule

bind minmaxavg minmaxavg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .mn(mn), .mx(mx), .avg(avg)
);

// File: tb/sim_minmaxavg.sv
module sim_minmaxavg;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int N  = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          start = 0;
  logic          done;
  logic [1:0]    sel = 2'b00;
  logic [DW-1:0] res;

  int total = 0;
  int bad   = 0;
  int shadow [N];

  always #5 clk = ~clk;

  minmaxavg #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .done(done), .sel(sel), .res(res)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int pat(input int p, input int i);
    case (p)
      0: return 255;
      1: return i;
      2: return 255 - i * 3;
      3: return (i * 37 + 11) & 255;
      4: return (i == 31) ? 1 : 200;
      5: return (i == 0) ? 250 : (i % 7) + 5;
      6: return 42;
      default: return (i * i * 13 + 7) % 256;
    endcase
  endfunction

  task automatic scan_and_check(input string tag);
    int cyc = 0, emin = 255, emax = 0, esum = 0;
    for (int i = 0; i < N; i++) begin
      esum += shadow[i];
      if (shadow[i] < emin) emin = shadow[i];
      if (shadow[i] > emax) emax = shadow[i];
    end
    @(negedge clk);
    start = 1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 100);
    chk({tag, " R2 latency"}, cyc, 34);
    sel = 2'b01; @(negedge clk); chk({tag, " R3 min"}, res, emin);
    sel = 2'b10; @(negedge clk); chk({tag, " R3 max"}, res, emax);
    sel = 2'b11; @(negedge clk); chk({tag, " R4 mean"}, res, esum / 32);
    sel = 2'b00; @(negedge clk); chk({tag, " R5 zero code"}, res, 0);
    chk({tag, " R6 done held"}, done, 1);
    start = 0;
    @(negedge clk);
    chk({tag, " R6 done dropped"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R8 done after reset", done, 0);
    for (int i = 0; i < N; i++) shadow[i] = 0;
    scan_and_check("R8 cleared bank");

    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < N; i++) begin
        shadow[i] = pat(p, i);
        wr(i, shadow[i]);
      end
      scan_and_check($sformatf("R1 pattern %0d", p));
    end

    for (int i = 0; i < N; i++) begin
      shadow[i] = 42;
      wr(i, 42);
    end
    @(negedge clk);
    start = 1;
    repeat (5) @(negedge clk);
    wr_en = 1; wr_addr = AW'(20); wr_data = 8'd255;
    @(negedge clk);
    wr_en = 0;
    while (!done) @(negedge clk);
    sel = 2'b10; @(negedge clk);
    chk("R7 max with write mid-scan", res, 42);
    start = 0;
    @(negedge clk);
    scan_and_check("R7 rescan after ignored write");

    wr(20, 255);
    shadow[20] = 255;
    scan_and_check("R1 idle write accepted");

    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R8 done low after second reset", done, 0);
    for (int i = 0; i < N; i++) shadow[i] = 0;
    scan_and_check("R8 bank cleared again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule